// File: doc/BRIEF.md
# Oscillator Trim Calibration Engine

This block finds the trim word for an on-chip digitally controlled oscillator so that the oscillator runs at a set multiple of a slow reference clock. Once started, it searches the 12-bit trim word one bit at a time, starting from the most significant bit. For each trial it drives the candidate word onto the trim output. It then counts how far a free-running fast-clock counter advances across a fixed number of reference periods. If that delta is no larger than the target, the trial bit is kept.

The target delta is a parameter. Set it to the wanted fast/reference frequency ratio times the window length in reference periods. The reference clock arrives asynchronously and is synchronised inside the block. The fast-clock counter is sampled as a plain bus.

When the search ends, one fixup is applied. If the three tap bits of the result are all ones, the five modulation bits are cleared. The resulting word is then driven as the final trim. `done` pulses for one cycle and the word holds until the next start.

Top module: `dco_trim_cal`

## Requirements
- R1: After reset, trim is 0x000 and busy and done are both low.
- R2: A start pulse while idle raises busy on the next cycle. The search then runs 12 trials with step weights 0x800 down to 0x001, halving each time. During each trial the trim output carries the word kept so far ORed with that trial's step.
- R3: A trial bit is kept when the measured delta is less than or equal to TARGET_DELTA, and dropped when the delta is larger. A delta exactly equal to the target keeps the bit.
- R4: The measured delta is the advance of fast_count, taken modulo 2^16, between the last two of NUM_SAMPLES samples. The samples are spaced WINDOW_TICKS rising edges of ref_clk_in apart. Counter wraparound does not disturb the result.
- R5: In the final word, if trim[7:5] (the tap field) is 3'b111, trim[4:0] (the modulation field) is forced to zero. Otherwise the search result is driven unchanged.
- R6: trim[10:8] (the range field) is searched like any other bit, with no correction for a non-monotonic frequency response. The result is whatever the bitwise search yields.
- R7: done is high for exactly one cycle per search. busy falls in that same cycle, and the final word is already on trim.
- R8: Between searches trim holds its final value. A start pulse while busy is ignored.
- R9: A start pulse in the same cycle as done is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| ref_clk_in | input | 1 | Slow reference clock, asynchronous |
| fast_count | input | 16 | Free-running count of oscillator edges |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the final word is applied |
| trim | output | 12 | Oscillator trim word |

## Verification
A search can end and a new start request can arrive in the same cycle. This is the cycle where busy falls and done pulses. The bench drives start in the very cycle it sees done. It then expects busy high on the next cycle and a second complete search, whose result is judged against a bench model running under a different oscillator response. The bench also drives a start in the middle of a search. It judges that case by checking that the result is unchanged and that only one done pulse follows.

// File: rtl/dco_trim_cal_pkg.sv
package dco_trim_cal_pkg;

    localparam int TRIM_W = 12;
    localparam int FAST_W = 16;

    typedef logic [TRIM_W-1:0] trim_t;
    typedef logic [FAST_W-1:0] fast_t;

    // Layout of the trim word as seen by the oscillator.
    typedef struct packed {
        logic       spare;
        logic [2:0] range;
        logic [2:0] tap;
        logic [4:0] modul;
    } trim_fields_t;

    typedef enum logic {
        SAR_IDLE    = 1'b0,
        SAR_MEASURE = 1'b1
    } sar_state_t;

    localparam trim_t TOP_STEP = trim_t'(1) << (TRIM_W - 1);

    // Modulation is meaningless at the highest tap, so clear it there.
    function automatic trim_t settle_word(trim_t w);
        trim_fields_t f;
        f = trim_fields_t'(w);
        if (&f.tap) begin
            f.modul = '0;
        end
        return trim_t'(f);
    endfunction

    function automatic fast_t wrap_diff(fast_t later, fast_t earlier);
        return later - earlier;
    endfunction

endpackage

// File: rtl/dco_ref_sync.sv
module dco_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic tick
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], ref_in};
        end
    end

    // Rising edge of the synchronised reference.
    assign tick = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/dco_window_meter.sv
module dco_window_meter
    import dco_trim_cal_pkg::*;
#(
    parameter int WINDOW_TICKS = 8,
    parameter int NUM_SAMPLES  = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  arm,
    input  logic  tick,
    input  fast_t fast_count,
    output logic  meas_valid,
    output fast_t meas_delta
);
    localparam int WCNT_W = $clog2(WINDOW_TICKS + 1);
    localparam int SIDX_W = $clog2(NUM_SAMPLES + 1);

    logic              active;
    logic [WCNT_W-1:0] wcnt;
    logic [SIDX_W-1:0] sidx;
    fast_t             prev_q, curr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            wcnt       <= '0;
            sidx       <= '0;
            prev_q     <= '0;
            curr_q     <= '0;
            meas_valid <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (arm) begin
                active <= 1'b1;
                wcnt   <= WCNT_W'(WINDOW_TICKS);
                sidx   <= '0;
            end else if (active && tick) begin
                if (wcnt == WCNT_W'(1)) begin
                    // Sample and re-arm on the same edge: windows abut exactly.
                    prev_q <= curr_q;
                    curr_q <= fast_count;
                    wcnt   <= WCNT_W'(WINDOW_TICKS);
                    sidx   <= sidx + SIDX_W'(1);
                    if (sidx == SIDX_W'(NUM_SAMPLES - 1)) begin
                        active     <= 1'b0;
                        meas_valid <= 1'b1;
                    end
                end else begin
                    wcnt <= wcnt - WCNT_W'(1);
                end
            end
        end
    end

    assign meas_delta = wrap_diff(curr_q, prev_q);
endmodule

// File: rtl/dco_sar_ctrl.sv
module dco_sar_ctrl
    import dco_trim_cal_pkg::*;
#(
    parameter fast_t TARGET_DELTA = fast_t'(1024)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  meas_valid,
    input  fast_t meas_delta,
    output logic  arm,
    output logic  busy,
    output logic  done,
    output trim_t trim
);
    sar_state_t state;
    trim_t      acc, step;
    trim_t      kept;
    logic       last_step;

    assign kept      = (meas_delta <= TARGET_DELTA) ? (acc | step) : acc;
    assign last_step = step[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SAR_IDLE;
            acc   <= '0;
            step  <= '0;
            trim  <= '0;
            arm   <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            arm  <= 1'b0;
            done <= 1'b0;
            unique case (state)
                SAR_IDLE: begin
                    if (start) begin
                        acc   <= '0;
                        step  <= TOP_STEP;
                        trim  <= TOP_STEP;
                        arm   <= 1'b1;
                        busy  <= 1'b1;
                        state <= SAR_MEASURE;
                    end
                end
                SAR_MEASURE: begin
                    if (meas_valid) begin
                        if (last_step) begin
                            trim  <= settle_word(kept);
                            acc   <= kept;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= SAR_IDLE;
                        end else begin
                            acc  <= kept;
                            step <= step >> 1;
                            trim <= kept | (step >> 1);
                            arm  <= 1'b1;
                        end
                    end
                end
                default: state <= SAR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dco_trim_cal.sv
module dco_trim_cal
    import dco_trim_cal_pkg::*;
#(
    parameter fast_t TARGET_DELTA = fast_t'(1024),
    parameter int    WINDOW_TICKS = 8,
    parameter int    NUM_SAMPLES  = 2,
    parameter int    SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ref_clk_in,
    input  logic [FAST_W-1:0] fast_count,
    output logic              busy,
    output logic              done,
    output logic [TRIM_W-1:0] trim
);
    logic  ref_tick;
    logic  arm;
    logic  meas_valid;
    fast_t meas_delta;

    dco_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_clk_in),
        .tick   (ref_tick)
    );

    dco_window_meter #(
        .WINDOW_TICKS (WINDOW_TICKS),
        .NUM_SAMPLES  (NUM_SAMPLES)
    ) u_meter (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .tick       (ref_tick),
        .fast_count (fast_count),
        .meas_valid (meas_valid),
        .meas_delta (meas_delta)
    );

    dco_sar_ctrl #(.TARGET_DELTA(TARGET_DELTA)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .meas_valid (meas_valid),
        .meas_delta (meas_delta),
        .arm        (arm),
        .busy       (busy),
        .done       (done),
        .trim       (trim)
    );
endmodule

// File: rtl/dco_trim_cal_chk.sv
module dco_trim_cal_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [11:0] trim
);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(trim));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_tap_fixup_R5: assert property (@(posedge clk) disable iff (rst)
        (done && (trim[7:5] == 3'b111)) |-> (trim[4:0] == 5'd0));
endmodule

bind dco_trim_cal dco_trim_cal_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .trim  (trim)
);

// File: tb/test_dco_trim_cal.sv
module test_dco_trim_cal;
    localparam int TGT    = 9600;
    localparam int WIN    = 8;
    localparam int REF_PD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ref_clk = 1'b0;
    logic [15:0] fast_count = 16'd0;
    logic        busy, done;
    logic [11:0] trim;

    int total = 0;
    int bad   = 0;
    int model = 0;
    int cycles = 0;
    logic [1:0] phase = 2'd0;

    logic [11:0] rec [0:15];
    int          nrec = 0;
    logic [11:0] last_seen = 12'd0;
    logic [11:0] exp_tr [0:11];

    always #2.5 clk = ~clk;

    dco_trim_cal #(
        .TARGET_DELTA (16'(TGT)),
        .WINDOW_TICKS (WIN),
        .NUM_SAMPLES  (2),
        .SYNC_STAGES  (2)
    ) i_dco_trim_cal (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ref_clk_in (ref_clk),
        .fast_count (fast_count),
        .busy       (busy),
        .done       (done),
        .trim       (trim)
    );

    // Oscillator response: edges per engine clock for a trim word.
    function automatic int rate_of(logic [11:0] w, int m);
        logic [11:0] s;
        case (m)
            1: begin
                s = w;
                s[10:8] = w[10:8] ^ 3'b101;
                return int'(s[11:2]) + 1;
            end
            2: return int'(w[11:2]) + 237;
            3: return 1;
            4: return 400;
            5: return int'(w[11:2]) + 2;
            default: return int'(w[11:2]) + 1;
        endcase
    endfunction

    always @(negedge clk) begin
        cycles <= cycles + 1;
        phase <= phase + 2'd1;
        ref_clk <= phase[1];
        fast_count <= fast_count + 16'(rate_of(trim, model));
        if (!rst && trim !== last_seen) begin
            if (nrec < 16) rec[nrec] = trim;
            nrec = nrec + 1;
        end
        last_seen = trim;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Bench model of the search, from the requirements.
    function automatic logic [11:0] expect_result(int m, bit fill);
        logic [11:0] c = 12'd0;
        for (int b = 11; b >= 0; b--) begin
            logic [11:0] w;
            w = c | (12'd1 << b);
            if (fill) exp_tr[11-b] = w;
            if (32'(WIN * REF_PD) * rate_of(w, m) <= TGT) c = w;
        end
        if (c[7:5] == 3'b111) c[4:0] = 5'd0;
        return c;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_case(input int m, input string req, input string name);
        bit ok;
        logic [11:0] e;
        model = m;
        e = expect_result(m, 1'b0);
        pulse_start();
        check(busy === 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
        wait_done(ok);
        check(ok, "R7", {name, " done seen"}, int'(ok), 1);
        check(trim === e, req, {name, " final trim"}, int'(trim), int'(e));
        check(busy === 1'b0, "R7", {name, " busy low at done"}, int'(busy), 0);
        @(negedge clk);
        check(done === 1'b0, "R7", {name, " done one cycle"}, int'(done), 0);
    endtask

    task automatic t_reset_and_trials();
        bit ok;
        logic [11:0] e;
        check(trim === 12'd0 && busy === 1'b0 && done === 1'b0, "R1",
              "reset state", int'({busy, done, trim}), 0);
        model = 0;
        e = expect_result(0, 1'b1);
        nrec = 0;
        pulse_start();
        wait_done(ok);
        check(ok, "R2", "first search completes", int'(ok), 1);
        check(nrec >= 12, "R2", "trial word count", nrec, 12);
        for (int i = 0; i < 12; i++)
            if (i < nrec)
                check(rec[i] === exp_tr[i], "R2", "trial word", int'(rec[i]), int'(exp_tr[i]));
        check(trim === e, "R3", "equal-to-target commits (model 0)", int'(trim), int'(e));
    endtask

    task automatic t_hold_and_busy_start();
        bit ok;
        logic [11:0] e, held;
        int extra = 0;
        held = trim;
        repeat (300) @(negedge clk);
        check(trim === held && busy === 1'b0, "R8", "trim holds while idle",
              int'(trim), int'(held));
        model = 1;
        e = expect_result(1, 1'b0);
        pulse_start();
        repeat (200) @(negedge clk);
        pulse_start();                       // mid-search, must be ignored
        wait_done(ok);
        check(ok && trim === e, "R8", "start while busy ignored", int'(trim), int'(e));
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check(extra == 0, "R8", "no second search after ignored start", extra, 0);
    endtask

    task automatic t_start_on_done();
        bit ok;
        logic [11:0] e;
        model = 0;
        pulse_start();
        wait_done(ok);
        model = 2;                           // start issued in the done cycle
        e = expect_result(2, 1'b0);
        pulse_start();
        check(busy === 1'b1, "R9", "start in done cycle accepted", int'(busy), 1);
        wait_done(ok);
        check(ok && trim === e, "R9", "restarted search result", int'(trim), int'(e));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_trials();
        run_case(5, "R3", "delta just above target drops bit");
        run_case(1, "R6", "non-monotonic range field");
        run_case(2, "R5", "tap saturated clears modulation");
        run_case(3, "R5", "all bits kept then fixup");
        run_case(4, "R3", "all trials over target");
        run_case(0, "R4", "wrapping counter delta");
        t_hold_and_busy_start();
        t_start_on_done();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule